// File: doc/BRIEF.md
# Interrupt Pin Message Generator

This block watches a vector of interrupt input pins and turns each new assertion of a pin into one interrupt message. Each pin has its own programmable routing entry, supplied as a flat input vector by a separate register block. On a rising pin, the block checks that entry's mask. If the pin is not masked, the block later builds a message that carries the entry's routing fields. The vector in that message comes from the entry itself, or, for the external-interrupt delivery mode, from a vector input driven by an outside legacy interrupt controller.

Accepted events wait in a pending set, one bit per pin. A fixed-priority arbiter serves the lowest-numbered pending pin first. The message is presented on a valid/ready handshake and held until the consumer accepts it. Destination resolution and transport of the message are left to downstream logic.

Each routing entry is 23 bits. Pin i occupies bits [i*23 +: 23] of `entries`. Inside an entry the fields are:
- [7:0] vector
- [10:8] delivery mode, where 3'b111 means external interrupt
- [11] destination mode
- [12] polarity
- [13] trigger mode
- [14] mask
- [22:15] destination

Top module: `irq_msg_gen`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, `msg_valid` is 0.
- R2: A pin is sampled at every rising clock edge. When a pin is sampled high after being sampled low, the block raises exactly one message. If the output is idle and no lower-numbered pin is waiting, that message appears on `msg_valid` after the second rising edge, counting the edge that sampled the pin high.
- R3: A pin that stays high raises no further messages.
- R4: A pin going low raises no message. A later low-to-high transition raises a new message.
- R5: If the mask bit (entry bit 14) is 1 at the edge where a pin is first sampled high, the event is dropped. The pin is still recorded as high, so clearing the mask while the pin stays high raises no message.
- R6: When the delivery mode field (entry bits [10:8]) is 3'b111, `msg_vector` is taken from `ext_vector`. For every other delivery mode it is entry bits [7:0].
- R7: Several message outputs copy fields of the served pin's entry. `msg_dest` takes bits [22:15], `msg_dmode` bits [10:8], `msg_dest_mode` bit 11, `msg_level` the polarity bit 12, and `msg_trigger` the trigger bit 13.
- R8: When several pins are pending, messages come out in ascending pin order, one per pending pin. With `msg_ready` held at 1 they come on consecutive cycles.
- R9: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and every message field stays unchanged.
- R10: A pin edge that arrives while the output is stalled is kept pending and is delivered after the stalled message has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | NPINS | Interrupt input pins, active high |
| entries | input | NPINS*23 | Routing entries, one 23-bit entry per pin |
| ext_vector | input | 8 | Vector supplied by the external legacy controller |
| msg_valid | output | 1 | A message is presented |
| msg_ready | input | 1 | Consumer accepts the message at this edge |
| msg_dest | output | 8 | Destination field |
| msg_vector | output | 8 | Interrupt vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_dest_mode | output | 1 | Destination mode |
| msg_level | output | 1 | Level, taken from the entry polarity |
| msg_trigger | output | 1 | Trigger mode |

## Verification
Two registers lie between a pin and its message: the pin sample together with the pending bit, and then the message register. A rise driven just after a falling clock edge is therefore checked as absent at the next falling edge and present at the one after. Each further pin served back-to-back is checked exactly one cycle later. Every input is driven right after a falling edge and every output is read at a falling edge, or 2 ns later in the random phase, so each check sits at a known cycle relative to the edge that produced it. Counting R5 and R3 as "no message" needs quiet windows of ten cycles, which is well beyond the two-cycle latency.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_EXTINT = 3'b111
  } dmode_e;

  // Bit layout, high to low: dest[22:15] mask[14] trig[13] pol[12]
  // dst_mode[11] dmode[10:8] vec[7:0]
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              pol;
    logic              dst_mode;
    dmode_e            dmode;
    logic [VEC_W-1:0]  vec;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vec;
    logic [2:0]        dmode;
    logic              dst_mode;
    logic              level;
    logic              trig;
  } msg_t;

  function automatic msg_t build_msg(entry_t e, logic [VEC_W-1:0] ext_vec);
    msg_t m;
    m.dest     = e.dest;
    m.vec      = (e.dmode == DM_EXTINT) ? ext_vec : e.vec;
    m.dmode    = e.dmode;
    m.dst_mode = e.dst_mode;
    m.level    = e.pol;
    m.trig     = e.trig;
    return m;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] rise
);

  logic [N-1:0] pin_q;
  logic [N-1:0] pin_d;

  // Remembered level follows the pin whether or not the edge is used.
  always_comb begin
    pin_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign rise = pins & ~pin_q;

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic         pend_en;

  always_comb begin
    pend_en = |set_i | |clr_i;
    pend_d  = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o
);

  logic found;

  // Lowest index wins.
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found    = 1'b1;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
  import irq_msg_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         irq_pins,
  input  logic [NPINS*ENTRY_W-1:0] entries,
  input  logic [VEC_W-1:0]         ext_vector,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [DEST_W-1:0]        msg_dest,
  output logic [VEC_W-1:0]         msg_vector,
  output logic [2:0]               msg_dmode,
  output logic                     msg_dest_mode,
  output logic                     msg_level,
  output logic                     msg_trigger
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  entry_t           ent [NPINS];
  logic [NPINS-1:0] mask_v;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] set_v;
  logic [NPINS-1:0] clr_v;
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] gnt;
  logic [IDX_W-1:0] gnt_idx;
  entry_t           sel;
  logic             load;
  msg_t             msg_q;
  msg_t             msg_d;
  logic             valid_q;
  logic             valid_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_unpack
    assign ent[i]    = entry_t'(entries[i*ENTRY_W +: ENTRY_W]);
    assign mask_v[i] = ent[i].mask;
  end

  irq_edge_detect #(.N(NPINS)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pins (irq_pins),
    .rise (rise)
  );

  // Mask is judged at the edge; a masked edge is lost.
  assign set_v = rise & ~mask_v;

  irq_pending #(.N(NPINS)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .pend_o(pend)
  );

  irq_prio_arb #(.N(NPINS), .IDX_W(IDX_W)) u_arb (
    .req_i(pend),
    .gnt_o(gnt),
    .idx_o(gnt_idx)
  );

  always_comb begin
    sel     = ent[gnt_idx];
    load    = (|pend) & (~valid_q | msg_ready);
    clr_v   = load ? gnt : '0;
    msg_d   = build_msg(sel, ext_vector);
    valid_d = load | (valid_q & ~msg_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= '0;
    end else if (load) begin
      msg_q <= msg_d;
    end
  end

  assign msg_valid     = valid_q;
  assign msg_dest      = msg_q.dest;
  assign msg_vector    = msg_q.vec;
  assign msg_dmode     = msg_q.dmode;
  assign msg_dest_mode = msg_q.dst_mode;
  assign msg_level     = msg_q.level;
  assign msg_trigger   = msg_q.trig;

endmodule

// File: rtl/irq_msg_gen_chk.sv
module irq_msg_gen_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_dest,
  input logic [7:0]       msg_vector,
  input logic [2:0]       msg_dmode,
  input logic             msg_dest_mode,
  input logic             msg_level,
  input logic             msg_trigger,
  input logic [7:0]       ext_vector,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] gnt
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_vector)
      && $stable(msg_dmode) && $stable(msg_dest_mode) && $stable(msg_level)
      && $stable(msg_trigger))); // R9

  AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && $past(!msg_valid || msg_ready) && msg_dmode == 3'b111)
      |-> (msg_vector == $past(ext_vector))); // R6

  AST_MSG_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && $past(!msg_valid || msg_ready)) |-> $past(|pend)); // R2

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8

  AST_GRANT_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~pend) == '0) && ((|pend) == (|gnt))); // R8

endmodule

bind irq_msg_gen irq_msg_gen_chk #(.NPINS(NPINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_dest     (msg_dest),
  .msg_vector   (msg_vector),
  .msg_dmode    (msg_dmode),
  .msg_dest_mode(msg_dest_mode),
  .msg_level    (msg_level),
  .msg_trigger  (msg_trigger),
  .ext_vector   (ext_vector),
  .pend         (pend),
  .gnt          (gnt)
);

// File: tb/tb_irq_msg_gen.sv
`timescale 1ns/1ps
module tb_irq_msg_gen;
  import irq_msg_pkg::*;

  localparam int N  = 8;
  localparam int EW = ENTRY_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    pins;
  logic [N*EW-1:0] entries;
  logic [7:0]      ext_vec;
  logic            ready;
  logic            valid;
  logic [7:0]      o_dest, o_vec;
  logic [2:0]      o_dmode;
  logic            o_dm, o_lvl, o_trig;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  irq_msg_gen #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .irq_pins(pins), .entries(entries),
    .ext_vector(ext_vec), .msg_valid(valid), .msg_ready(ready),
    .msg_dest(o_dest), .msg_vector(o_vec), .msg_dmode(o_dmode),
    .msg_dest_mode(o_dm), .msg_level(o_lvl), .msg_trigger(o_trig)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk(logic [7:0] dest, logic mask, logic trig,
                                       logic pol, logic dm, logic [2:0] dmode,
                                       logic [7:0] vec);
    return {dest, mask, trig, pol, dm, dmode, vec};
  endfunction

  function automatic logic [EW-1:0] ent_of(int i);
    return entries[i*EW +: EW];
  endfunction

  function automatic logic [7:0] exp_vec(logic [EW-1:0] e);
    return (e[10:8] == 3'b111) ? ext_vec : e[7:0];
  endfunction

  task automatic chk_msg(string req, logic [EW-1:0] e);
    chk(req, "valid",     valid,   1);
    chk(req, "dest",      o_dest,  e[22:15]);
    chk(req, "vector",    o_vec,   exp_vec(e));
    chk(req, "dmode",     o_dmode, e[10:8]);
    chk(req, "dest_mode", o_dm,    e[11]);
    chk(req, "level",     o_lvl,   e[12]);
    chk(req, "trigger",   o_trig,  e[13]);
  endtask

  task automatic quiet(string req, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, "no message", valid, 0);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  logic [EW-1:0] rent [N];
  int exp_cnt [N];
  int got_cnt [N];
  int tmr [N];

  task automatic observe();
    if (valid && ready) begin
      int p;
      p = int'(o_vec) - 'h40;
      if (p >= 0 && p < N) begin
        got_cnt[p]++;
        chk("R7", "random dest",  o_dest,  rent[p][22:15]);
        chk("R7", "random dmode", o_dmode, rent[p][10:8]);
        chk("R7", "random level", o_lvl,   rent[p][12]);
        chk("R7", "random trig",  o_trig,  rent[p][13]);
      end else begin
        chk("R7", "random vector in range", o_vec, 8'h40);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n   = 1'b0;
    pins    = '0;
    ready   = 1'b1;
    ext_vec = 8'h9C;
    for (int i = 0; i < N; i++)
      entries[i*EW +: EW] = mk(8'h10 + 8'(i), 0, 0, 0, 0, 3'b000, 8'h40 + 8'(i));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", valid, 0);

    // R2 / R7: single edge, exact latency, field copy
    entries[0*EW +: EW] = mk(8'hA5, 0, 0, 1, 1, 3'b001, 8'h41);
    pins[0] = 1'b1;
    @(negedge clk);
    chk("R2", "valid one edge after rise", valid, 0);
    @(negedge clk);
    chk_msg("R7", ent_of(0));
    @(negedge clk);
    chk("R2", "single message", valid, 0);

    // R3: held high
    quiet("R3", 10);

    // R4: falling edge silent, new rise counts
    pins[0] = 1'b0;
    quiet("R4", 10);
    pins[0] = 1'b1;
    @(negedge clk);
    chk("R4", "valid one edge after re-rise", valid, 0);
    @(negedge clk);
    chk_msg("R4", ent_of(0));
    @(negedge clk);

    // R6: external vector
    entries[1*EW +: EW] = mk(8'h03, 0, 1, 0, 0, 3'b111, 8'h22);
    pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_msg("R6", ent_of(1));
    chk("R6", "ext vector used", o_vec, 8'h9C);
    @(negedge clk);

    // R5: masked edge lost, not deferred
    entries[2*EW +: EW] = mk(8'h11, 1, 0, 0, 0, 3'b000, 8'h33);
    pins[2] = 1'b1;
    quiet("R5", 10);
    entries[2*EW +: EW] = mk(8'h11, 0, 0, 0, 0, 3'b000, 8'h33);
    quiet("R5", 10);
    pins[2] = 1'b0;
    @(negedge clk);
    pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_msg("R5", ent_of(2));
    @(negedge clk);

    // R8: simultaneous edges in ascending order
    pins[3] = 1'b1; pins[5] = 1'b1; pins[6] = 1'b1;
    @(negedge clk);
    chk("R8", "not yet", valid, 0);
    @(negedge clk);
    chk_msg("R8", ent_of(3));
    @(negedge clk);
    chk_msg("R8", ent_of(5));
    @(negedge clk);
    chk_msg("R8", ent_of(6));
    @(negedge clk);
    chk("R8", "drained", valid, 0);

    // R9 / R10: stall holds message; edge during stall kept
    ready   = 1'b0;
    pins[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_msg("R9", ent_of(4));
    pins[7] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_msg("R9", ent_of(4));
    end
    ready = 1'b1;
    @(negedge clk);
    chk_msg("R10", ent_of(7));
    @(negedge clk);
    chk("R10", "drained", valid, 0);

    pins = '0;
    repeat (5) @(negedge clk);

    // Random phase (R2, R7, R8)
    for (int i = 0; i < N; i++) begin
      logic [2:0] dm;
      case ($urandom % 4)
        0: dm = 3'b000;
        1: dm = 3'b001;
        2: dm = 3'b100;
        default: dm = 3'b010;
      endcase
      rent[i] = mk(8'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
                   1'($urandom), dm, 8'h40 + 8'(i));
      entries[i*EW +: EW] = rent[i];
      exp_cnt[i] = 0;
      got_cnt[i] = 0;
      tmr[i]     = int'($urandom % 40);
    end
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      ready = ($urandom % 4) != 0;
      for (int i = 0; i < N; i++) begin
        if (tmr[i] == 0) begin
          if (!pins[i] && !rent[i][14]) exp_cnt[i]++;
          pins[i] = ~pins[i];
          tmr[i]  = 40 + int'($urandom % 20);
        end else begin
          tmr[i]--;
        end
      end
      #2;
      observe();
    end
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      pins  = '0;
      ready = 1'b1;
      #2;
      observe();
    end
    for (int i = 0; i < N; i++)
      chk("R2", $sformatf("message count pin %0d", i), got_cnt[i], exp_cnt[i]);

    done = 1'b1;
    report();
    $finish;
  end

endmodule